// File: doc/BRIEF.md
# PHY Clock-Change Sequencer

This block reprograms the delay, frequency and DLL controls of a memory-card interface PHY each time the card clock frequency is changed. A request carries the new frequency in kHz and a flag for the strobe-based double-data-rate timing mode. Static inputs supply the output tap delay, the DLL charge-pump trim, the drive-strength code and the strobe select.

The sequencer performs one register step per cycle, in a fixed order:

1. Turn the DLL off.
2. Load the new clock.
3. Write the tap delay.
4. Write the strobe select.
5. Write the frequency select.
6. Write the trim and drive fields.
7. Turn the DLL back on.
8. Sample the DLL-ready status at fixed intervals until it is seen or a timeout expires.

Every write changes only the bits of its own field in three 32-bit control words: a DLL word, a delay word and a frequency word. For very slow clocks the sequence stops right after the clock load.

After reset the block runs a one-time start-up pass before it accepts any request. This pass clears the tap-delay fields. If a DLL is present and calibration is not yet complete, it also raises the power-up bit and waits, with a timeout, for calibration to finish.

Top module: `phy_clkseq`

## Requirements
- R1: When a request is accepted and the DLL is flagged on, the DLL enable bit (bit 1 of the DLL word) is cleared one cycle after acceptance, before the clock load one cycle later. If the DLL is flagged off, for example after a lock timeout, the bit is left as it is.
- R2: For a frequency at or below SLOW_KHZ (400 kHz), the clock is loaded and done pulses 2 cycles after acceptance. The DLL flag stays off, and the delay and frequency words are unchanged. 401 kHz takes the full sequence.
- R3: Above SLOW_KHZ, bit 20 of the delay word is set and bits 15:12 receive the tap value.
- R4: Only when the request is in strobe mode are the strobe bits written, starting at bit 24 of the delay word. The field is 4 bits wide when STROBE_NARROW=1 and 8 bits wide otherwise; bits above a 4-bit field keep their value. Outside strobe mode the strobe bits are unchanged.
- R5: With FSEL_TWO_BIT=1, the pair {bit9, bit8} of the frequency word is 00 for 200000 kHz, 10 for 100000 kHz and 01 for any other frequency.
- R6: With FSEL_TWO_BIT=0, bits 10:8 of the frequency word are 0 for 200000 kHz and 4 for any other frequency.
- R7: The trim value goes to bits 7:4 of the DLL word and the drive code to bits 22:20. The drive codes are 0=50, 1=33, 2=66, 3=100 and 4=40 ohm. The enable bit 1 is then set, and a successful lock leaves both bit 1 and the DLL flag on.
- R8: DLL-ready is sampled every POLL_CYC cycles after the enable, at most POLL_MAX times. Done pulses 7+k*POLL_CYC cycles after acceptance, where k is the first sample that sees ready. If no sample sees ready, error is raised at 7+POLL_MAX*POLL_CYC and the DLL flag stays off.
- R9: At start-up with a DLL present and calibration-done low, the power-up bit (bit 0 of the DLL word) is set and never cleared afterwards. If calibration-done is not seen within CAL_CYC cycles, error is raised and busy drops 2+CAL_CYC cycles after reset release.
- R10: The start-up pass leaves the tap enable (bit 20) and the tap field (bits 15:12) of the delay word at zero.
- R11: busy is high from reset until the start-up pass ends, and from acceptance until done. A request that arrives while busy is ignored and produces no later done.
- R12: done is a single-cycle pulse. error is sticky and is cleared on the cycle after the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Clock-change request, accepted when idle |
| req_khz | input | FREQ_W | Requested card clock in kHz |
| req_strobe_mode | input | 1 | Request is for strobe double-rate timing |
| cfg_tap | input | 4 | Output tap delay value |
| cfg_trim | input | 4 | DLL charge-pump trim |
| cfg_drive | input | 3 | Drive-strength code |
| cfg_strobe | input | 8 | Strobe select value |
| dll_ready | input | 1 | DLL locked status |
| cal_done | input | 1 | Calibration complete status |
| dll_ctrl | output | 32 | DLL control word |
| delay_ctrl | output | 32 | Delay control word |
| freq_ctrl | output | 32 | Frequency control word |
| clk_load | output | 1 | One-cycle strobe to load the new clock |
| clk_khz | output | FREQ_W | Frequency handed to the clock divider |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-cycle sequence completion pulse |
| err | output | 1 | Sticky lock or calibration failure |

## Verification
Each result has a fixed cycle after acceptance:

- The DLL disable lands after edge 1 and the clock load after edge 2; a slow request also completes after edge 2.
- The fast path finishes after edge 7+k*POLL_CYC, where k is set by the bench's DLL model: a lock after ten enabled cycles gives k=2, and a DLL already locked gives k=1.
- A timeout ends after edge 7+POLL_MAX*POLL_CYC.
- The calibration failure appears at edge 2+CAL_CYC after reset release.

The bench counts rising edges from the accepting edge, samples every output on the following falling edge, and compares the count at which done appears with these figures.

// File: rtl/phy_clkseq_pkg.sv
package phy_clkseq_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [3:0] {
        S_INIT_TAP,
        S_INIT_CHK,
        S_INIT_WAIT,
        S_IDLE,
        S_DLL_OFF,
        S_CLK_SET,
        S_TAP,
        S_STRB,
        S_FREQ,
        S_TRIM,
        S_DLL_ON,
        S_POLL
    } seq_state_e;

    // DLL word
    localparam int unsigned PWRUP_BIT  = 0;
    localparam int unsigned DLLEN_BIT  = 1;
    localparam int unsigned TRIM_LSB   = 4;
    localparam int unsigned DRIVE_LSB  = 20;
    // delay word
    localparam int unsigned TAP_LSB    = 12;
    localparam int unsigned TAPEN_BIT  = 20;
    localparam int unsigned STRB_LSB   = 24;
    // frequency word
    localparam int unsigned FSEL_LSB   = 8;

    localparam word_t PWRUP_MASK = word_t'(1) << PWRUP_BIT;
    localparam word_t DLLEN_MASK = word_t'(1) << DLLEN_BIT;
    localparam word_t TAP_MASK   = (word_t'(1) << TAPEN_BIT) | (word_t'(4'hF) << TAP_LSB);

    function automatic word_t merge(input word_t cur, input word_t mask, input word_t val);
        return (cur & ~mask) | (val & mask);
    endfunction

endpackage

// File: rtl/phy_clkseq_fields.sv
module phy_clkseq_fields
    import phy_clkseq_pkg::*;
#(
    parameter int FREQ_W        = 20,
    parameter int SLOW_KHZ      = 400,
    parameter int FAST_KHZ      = 200000,
    parameter int MID_KHZ       = 100000,
    parameter bit FSEL_TWO_BIT  = 1'b1,
    parameter bit STROBE_NARROW = 1'b1
) (
    input  logic [FREQ_W-1:0] khz,
    input  logic [3:0]        tap,
    input  logic [3:0]        trim,
    input  logic [2:0]        drive,
    input  logic [7:0]        strobe,
    output logic              is_slow,
    output word_t             tap_val,
    output word_t             strb_mask,
    output word_t             strb_val,
    output word_t             freq_mask,
    output word_t             freq_val,
    output word_t             trim_mask,
    output word_t             trim_val
);
    localparam logic [FREQ_W-1:0] SLOW_LIM = FREQ_W'(SLOW_KHZ);
    localparam logic [FREQ_W-1:0] FAST_VAL = FREQ_W'(FAST_KHZ);
    localparam logic [FREQ_W-1:0] MID_VAL  = FREQ_W'(MID_KHZ);

    logic is_fast, is_mid;

    always_comb begin
        is_slow = (khz <= SLOW_LIM);
        is_fast = (khz == FAST_VAL);
        is_mid  = (khz == MID_VAL);
        tap_val = (word_t'(1) << TAPEN_BIT) | (word_t'(tap) << TAP_LSB);
        trim_mask = (word_t'(4'hF) << TRIM_LSB) | (word_t'(3'h7) << DRIVE_LSB);
        trim_val  = (word_t'(trim) << TRIM_LSB) | (word_t'(drive) << DRIVE_LSB);
    end

    generate
        if (FSEL_TWO_BIT) begin : g_fsel2
            logic sel_lo, sel_hi;
            always_comb begin
                sel_lo    = !(is_fast || is_mid);
                sel_hi    = is_mid;
                freq_mask = word_t'(2'b11) << FSEL_LSB;
                freq_val  = word_t'({sel_hi, sel_lo}) << FSEL_LSB;
            end
        end else begin : g_fsel3
            always_comb begin
                freq_mask = word_t'(3'b111) << FSEL_LSB;
                freq_val  = word_t'(is_fast ? 3'd0 : 3'd4) << FSEL_LSB;
            end
        end

        if (STROBE_NARROW) begin : g_strb4
            always_comb begin
                strb_mask = word_t'(4'hF) << STRB_LSB;
                strb_val  = word_t'(strobe[3:0]) << STRB_LSB;
            end
        end else begin : g_strb8
            always_comb begin
                strb_mask = word_t'(8'hFF) << STRB_LSB;
                strb_val  = word_t'(strobe) << STRB_LSB;
            end
        end
    endgenerate

endmodule

// File: rtl/phy_clkseq_timer.sv
module phy_clkseq_timer #(
    parameter int INTERVAL = 8,
    parameter int COUNT    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic interval_end,
    output logic final_end
);
    localparam int TW = $clog2(INTERVAL + 1);
    localparam int CW = $clog2(COUNT + 1);

    typedef struct packed {
        logic [TW-1:0] tick;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign interval_end = run && (t_q.tick == TW'(INTERVAL - 1));
    assign final_end    = interval_end && (t_q.cnt == CW'(COUNT - 1));

    always_comb begin
        t_d = t_q;
        if (!run) begin
            t_d = '0;
        end else if (interval_end) begin
            t_d.tick = '0;
            if (!final_end) t_d.cnt = t_q.cnt + 1'b1;
        end else begin
            t_d.tick = t_q.tick + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(t_q.tick) < INTERVAL); // R8
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        32'(t_q.cnt) < COUNT); // R8

endmodule

// File: rtl/phy_clkseq.sv
module phy_clkseq
    import phy_clkseq_pkg::*;
#(
    parameter int FREQ_W        = 20,
    parameter int SLOW_KHZ      = 400,
    parameter int FAST_KHZ      = 200000,
    parameter int MID_KHZ       = 100000,
    parameter int POLL_CYC      = 125000,
    parameter int POLL_MAX      = 1000,
    parameter int CAL_CYC       = 2500,
    parameter bit FSEL_TWO_BIT  = 1'b1,
    parameter bit STROBE_NARROW = 1'b1,
    parameter bit DLL_PRESENT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [FREQ_W-1:0] req_khz,
    input  logic              req_strobe_mode,
    input  logic [3:0]        cfg_tap,
    input  logic [3:0]        cfg_trim,
    input  logic [2:0]        cfg_drive,
    input  logic [7:0]        cfg_strobe,
    input  logic              dll_ready,
    input  logic              cal_done,
    output logic [31:0]       dll_ctrl,
    output logic [31:0]       delay_ctrl,
    output logic [31:0]       freq_ctrl,
    output logic              clk_load,
    output logic [FREQ_W-1:0] clk_khz,
    output logic              busy,
    output logic              done,
    output logic              err
);
    typedef struct packed {
        seq_state_e        st;
        word_t             dll;
        word_t             dly;
        word_t             frq;
        logic [FREQ_W-1:0] khz;
        logic [FREQ_W-1:0] clk_khz;
        logic              strb_mode;
        logic              clk_load;
        logic              dll_on;
        logic              done;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic  is_slow;
    word_t f_tap_val, f_strb_mask, f_strb_val, f_freq_mask, f_freq_val;
    word_t f_trim_mask, f_trim_val;
    logic  poll_end, poll_final, cal_end_unused, cal_final;

    phy_clkseq_fields #(
        .FREQ_W(FREQ_W), .SLOW_KHZ(SLOW_KHZ), .FAST_KHZ(FAST_KHZ), .MID_KHZ(MID_KHZ),
        .FSEL_TWO_BIT(FSEL_TWO_BIT), .STROBE_NARROW(STROBE_NARROW)
    ) u_fields (
        .khz(r_q.khz), .tap(cfg_tap), .trim(cfg_trim), .drive(cfg_drive),
        .strobe(cfg_strobe), .is_slow(is_slow), .tap_val(f_tap_val),
        .strb_mask(f_strb_mask), .strb_val(f_strb_val),
        .freq_mask(f_freq_mask), .freq_val(f_freq_val),
        .trim_mask(f_trim_mask), .trim_val(f_trim_val)
    );

    phy_clkseq_timer #(.INTERVAL(POLL_CYC), .COUNT(POLL_MAX)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n), .run(r_q.st == S_POLL),
        .interval_end(poll_end), .final_end(poll_final)
    );

    phy_clkseq_timer #(.INTERVAL(1), .COUNT(CAL_CYC)) u_cal_tmr (
        .clk(clk), .rst_n(rst_n), .run(r_q.st == S_INIT_WAIT),
        .interval_end(cal_end_unused), .final_end(cal_final)
    );

    always_comb begin
        r_d          = r_q;
        r_d.clk_load = 1'b0;
        r_d.done     = 1'b0;
        case (r_q.st)
            S_INIT_TAP: begin
                r_d.dly = merge(r_q.dly, TAP_MASK, '0);
                r_d.st  = S_INIT_CHK;
            end
            S_INIT_CHK: begin
                if (DLL_PRESENT && !cal_done) begin
                    r_d.dll = merge(r_q.dll, PWRUP_MASK, PWRUP_MASK);
                    r_d.st  = S_INIT_WAIT;
                end else begin
                    r_d.st = S_IDLE;
                end
            end
            S_INIT_WAIT: begin
                if (cal_done) begin
                    r_d.st = S_IDLE;
                end else if (cal_final) begin
                    r_d.err = 1'b1;
                    r_d.st  = S_IDLE;
                end
            end
            S_IDLE: begin
                if (req) begin
                    r_d.khz       = req_khz;
                    r_d.strb_mode = req_strobe_mode;
                    r_d.err       = 1'b0;
                    r_d.st        = S_DLL_OFF;
                end
            end
            S_DLL_OFF: begin
                if (r_q.dll_on) begin
                    r_d.dll    = merge(r_q.dll, DLLEN_MASK, '0);
                    r_d.dll_on = 1'b0;
                end
                r_d.st = S_CLK_SET;
            end
            S_CLK_SET: begin
                r_d.clk_load = 1'b1;
                r_d.clk_khz  = r_q.khz;
                if (is_slow) begin
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end else begin
                    r_d.st = S_TAP;
                end
            end
            S_TAP: begin
                r_d.dly = merge(r_q.dly, TAP_MASK, f_tap_val);
                r_d.st  = S_STRB;
            end
            S_STRB: begin
                if (r_q.strb_mode) r_d.dly = merge(r_q.dly, f_strb_mask, f_strb_val);
                r_d.st = S_FREQ;
            end
            S_FREQ: begin
                r_d.frq = merge(r_q.frq, f_freq_mask, f_freq_val);
                r_d.st  = S_TRIM;
            end
            S_TRIM: begin
                r_d.dll = merge(r_q.dll, f_trim_mask, f_trim_val);
                r_d.st  = S_DLL_ON;
            end
            S_DLL_ON: begin
                r_d.dll = merge(r_q.dll, DLLEN_MASK, DLLEN_MASK);
                r_d.st  = S_POLL;
            end
            S_POLL: begin
                if (poll_end && dll_ready) begin
                    r_d.dll_on = 1'b1;
                    r_d.done   = 1'b1;
                    r_d.st     = S_IDLE;
                end else if (poll_final) begin
                    r_d.err  = 1'b1;
                    r_d.done = 1'b1;
                    r_d.st   = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_INIT_TAP;
        end else begin
            r_q <= r_d;
        end
    end

    assign dll_ctrl   = r_q.dll;
    assign delay_ctrl = r_q.dly;
    assign freq_ctrl  = r_q.frq;
    assign clk_load   = r_q.clk_load;
    assign clk_khz    = r_q.clk_khz;
    assign busy       = (r_q.st != S_IDLE);
    assign done       = r_q.done;
    assign err        = r_q.err;

    AST_DLL_OFF_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        clk_load |-> !r_q.dll_on); // R1
    AST_SLOW_DLL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && clk_khz <= FREQ_W'(SLOW_KHZ)) |-> !r_q.dll_on); // R2
    AST_LOCK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && clk_khz > FREQ_W'(SLOW_KHZ)) |-> (dll_ctrl[DLLEN_BIT] && r_q.dll_on)); // R7
    AST_FAIL_FLAG_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !r_q.dll_on); // R8
    AST_PWRUP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(dll_ctrl[PWRUP_BIT])); // R9
    AST_IGNORE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req) |=> $stable(r_q.khz)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R12

endmodule

// File: tb/phy_clkseq_test.sv
`timescale 1ns/1ps
module phy_clkseq_test;
    localparam int FW   = 20;
    localparam int PC   = 8;
    localparam int PM   = 5;
    localparam int CC   = 16;
    localparam int LOCK = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [FW-1:0] req_khz = '0;
    logic strb_mode = 1'b0;
    logic [3:0] cfg_tap = 4'h9, cfg_trim = 4'h6;
    logic [2:0] cfg_drive = 3'd4;
    logic [7:0] cfg_strobe = 8'hA5;
    logic cal_ok = 1'b1, dll_ok = 1'b1;
    logic cal_done, rdy1, rdy2;
    logic [31:0] dll1, dly1, frq1, dll2, dly2, frq2;
    logic ld1, ld2, busy1, busy2, done1, done2, err1, err2;
    logic [FW-1:0] khz1, khz2;
    int total = 0, bad = 0;
    int cal_cnt = 0, lk1 = 0, lk2 = 0;
    int e1_bit, e1_load, e2_load, e1_err;

    always #4 clk = ~clk;

    phy_clkseq #(.FREQ_W(FW), .POLL_CYC(PC), .POLL_MAX(PM), .CAL_CYC(CC),
                 .FSEL_TWO_BIT(1'b1), .STROBE_NARROW(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_khz(req_khz), .req_strobe_mode(strb_mode),
        .cfg_tap(cfg_tap), .cfg_trim(cfg_trim), .cfg_drive(cfg_drive), .cfg_strobe(cfg_strobe),
        .dll_ready(rdy1), .cal_done(cal_done), .dll_ctrl(dll1), .delay_ctrl(dly1),
        .freq_ctrl(frq1), .clk_load(ld1), .clk_khz(khz1), .busy(busy1), .done(done1), .err(err1));

    phy_clkseq #(.FREQ_W(FW), .POLL_CYC(PC), .POLL_MAX(PM), .CAL_CYC(CC),
                 .FSEL_TWO_BIT(1'b0), .STROBE_NARROW(1'b0)) uut2 (
        .clk(clk), .rst_n(rst_n), .req(req), .req_khz(req_khz), .req_strobe_mode(strb_mode),
        .cfg_tap(cfg_tap), .cfg_trim(cfg_trim), .cfg_drive(cfg_drive), .cfg_strobe(cfg_strobe),
        .dll_ready(rdy2), .cal_done(cal_done), .dll_ctrl(dll2), .delay_ctrl(dly2),
        .freq_ctrl(frq2), .clk_load(ld2), .clk_khz(khz2), .busy(busy2), .done(done2), .err(err2));

    // calibration and DLL models
    always @(posedge clk) begin
        cal_cnt <= (!rst_n || !dll1[0]) ? 0 : (cal_cnt < 3 ? cal_cnt + 1 : cal_cnt);
        lk1 <= !dll1[1] ? 0 : (lk1 < 255 ? lk1 + 1 : lk1);
        lk2 <= !dll2[1] ? 0 : (lk2 < 255 ? lk2 + 1 : lk2);
    end
    assign cal_done = cal_ok && (cal_cnt >= 3);
    assign rdy1 = dll_ok && (lk1 >= LOCK);
    assign rdy2 = dll_ok && (lk2 >= LOCK);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic cal_v);
        @(negedge clk);
        rst_n = 1'b0;
        cal_ok = cal_v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_req(input int khz, input logic sm, input int ign_khz, output int n);
        @(negedge clk);
        req = 1'b1; req_khz = FW'(khz); strb_mode = sm;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 1) begin e1_bit = dll1[1]; e1_load = ld1; e1_err = err1; end
            if (n == 2) e2_load = ld1;
            if (ign_khz > 0 && n == 10) begin req = 1'b1; req_khz = FW'(ign_khz); end
            if (n == 11) req = 1'b0;
            if (done1) break;
        end
        chk("R8 twin done", 32'(done2), 32'(done1));
    endtask

    task automatic t_reset_ok();
        int n = 0;
        @(negedge clk);
        rst_n = 1'b0;
        cal_ok = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 reset busy", 32'(busy1), 1);
        chk("R9 reset dll word", dll1, 0);
        chk("R12 reset done/err", {done1, err1}, 0);
        rst_n = 1'b1;
        while (busy1 && n < 60) begin @(negedge clk); n++; end
        chk("R11 init ends", 32'(busy1), 0);
        chk("R9 power-up bit", 32'(dll1[0]), 1);
        chk("R9 no cal error", 32'(err1), 0);
        chk("R10 tap fields", {dly1[20], dly1[15:12]}, 0);
    endtask

    task automatic t_fast200();
        int n;
        cfg_tap = 4'h9; cfg_trim = 4'h6; cfg_drive = 3'd4; cfg_strobe = 8'hA5;
        do_req(200000, 1'b0, 0, n);
        chk("R8 lock at k=2", n, 7 + 2 * PC);
        chk("R3 tap enable", 32'(dly1[20]), 1);
        chk("R3 tap value", 32'(dly1[15:12]), 4'h9);
        chk("R4 strobe untouched", 32'(dly1[31:24]), 0);
        chk("R5 200M sel", 32'(frq1[9:8]), 2'b00);
        chk("R6 200M sel", 32'(frq2[10:8]), 0);
        chk("R7 trim", 32'(dll1[7:4]), 4'h6);
        chk("R7 drive", 32'(dll1[22:20]), 3'd4);
        chk("R7 dll enable", 32'(dll1[1]), 1);
        chk("R8 no error", 32'(err1), 0);
        @(negedge clk);
        chk("R12 done single", 32'(done1), 0);
    endtask

    task automatic t_fast100_strobe();
        int n;
        do_req(100000, 1'b1, 0, n);
        chk("R1 dll off at edge 1", 32'(e1_bit), 0);
        chk("R1 no load at edge 1", 32'(e1_load), 0);
        chk("R1 load at edge 2", 32'(e2_load), 1);
        chk("R8 lock at k=2", n, 7 + 2 * PC);
        chk("R5 100M sel", 32'(frq1[9:8]), 2'b10);
        chk("R6 100M sel", 32'(frq2[10:8]), 4);
        chk("R4 narrow strobe", 32'(dly1[31:24]), 8'h05);
        chk("R4 wide strobe", 32'(dly2[31:24]), 8'hA5);
    endtask

    task automatic t_other_freq();
        int n;
        cfg_strobe = 8'h3C; cfg_tap = 4'h3;
        do_req(50000, 1'b0, 0, n);
        chk("R5 other sel", 32'(frq1[9:8]), 2'b01);
        chk("R6 other sel", 32'(frq2[10:8]), 4);
        chk("R4 narrow kept", 32'(dly1[31:24]), 8'h05);
        chk("R4 wide kept", 32'(dly2[31:24]), 8'hA5);
        chk("R3 new tap", 32'(dly1[15:12]), 4'h3);
    endtask

    task automatic t_slow();
        int n;
        logic [31:0] dly_s, frq_s;
        dly_s = dly1; frq_s = frq1;
        cfg_tap = 4'hE;
        do_req(400, 1'b1, 0, n);
        chk("R2 done at edge 2", n, 2);
        chk("R2 clock loaded", 32'(khz1), 400);
        chk("R2 dll off", 32'(dll1[1]), 0);
        chk("R2 delay kept", dly1, dly_s);
        chk("R2 freq kept", frq1, frq_s);
        chk("R11 idle after", 32'(busy1), 0);
        do_req(401, 1'b0, 0, n);
        chk("R2 401 full path", n, 7 + 2 * PC);
        chk("R3 tap at 401", 32'(dly1[15:12]), 4'hE);
    endtask

    task automatic t_timeout();
        int n;
        dll_ok = 1'b0;
        do_req(200000, 1'b0, 0, n);
        chk("R8 timeout cycle", n, 7 + PM * PC);
        chk("R8 error", 32'(err1), 1);
        chk("R8 enable bit left", 32'(dll1[1]), 1);
        repeat (5) @(negedge clk);
        chk("R12 error sticky", 32'(err1), 1);
        dll_ok = 1'b1;
        do_req(200000, 1'b0, 0, n);
        chk("R12 error cleared", 32'(e1_err), 0);
        chk("R1 flag off keeps bit", 32'(e1_bit), 1);
        chk("R8 prelocked k=1", n, 7 + PC);
        chk("R8 recovered", 32'(err1), 0);
    endtask

    task automatic t_busy_ignore();
        int n;
        int extra = 0;
        do_req(200000, 1'b0, 123, n);
        chk("R11 busy run", n, 7 + 2 * PC);
        chk("R11 clock not taken", 32'(khz1), 200000);
        repeat (20) begin @(negedge clk); if (done1) extra++; end
        chk("R11 no extra done", extra, 0);
    endtask

    task automatic t_cal_fail();
        int n = 0;
        do_reset(1'b0);
        while (n < 2 + CC - 1) begin @(posedge clk); n++; end
        @(negedge clk);
        chk("R9 still calibrating", 32'(busy1), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 cal timeout", {busy1, err1}, 2'b01);
        chk("R9 power-up bit set", 32'(dll1[0]), 1);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset_ok();
        t_fast200();
        t_fast100_strobe();
        t_other_freq();
        t_slow();
        t_timeout();
        t_busy_ignore();
        t_cal_fail();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule